// File: doc/BRIEF.md
# Single-Wire Pulse-Timing Frame Capture

This block watches one data line that rests high and is pulled low in pulses. It cuts the traffic into frames at long idle-high stretches and samples every bit time at its centre. Each edge re-aligns the sampling point, so timing noise does not build up over a frame. For every frame it reports the sampled levels and a one-bit type taken from the length of the opening low pulse: one bit period or three. It raises an error flag when the edge count or the opening pulse does not match the expected shape. It does not interpret the data.

A free-running tick input sets the time base: one bit period is `OVS` ticks. After reset the block stays passive until it has seen one full idle gap, so it never reports a frame that was already under way. A low run that lasts too long ends the frame at once with an error. Capture then resumes only after the next idle gap. Two counters hold running totals of good long-type and good short-type frames, so a start-up sequence of frames can be checked against the expected mix.

Top module: `pulse_frame_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, `frame_valid_o`, `frame_type_o`, `frame_err_o`, `frame_bits_o`, `long_cnt_o` and `short_cnt_o` are all zero.
- R2: After reset no frame is reported until the line has stayed high for at least `GAP_BITS` (6) bit periods. Pulses before that produce no strobe.
- R3: A frame opens on a falling edge after an idle gap. `frame_bits_o[i]` is the line level at the centre of bit time i, with i=0 being the bit time that starts at the opening edge. Positions never sampled read 1. Bits and flags hold their value between strobes.
- R4: `frame_type_o` is 1 when the opening low lasts 3 bit periods and 0 when it lasts 1 bit period.
- R5: A frame closes only when a high run reaches `GAP_BITS` (6) bit periods. A high run of 5 bit periods inside a frame does not close it.
- R6: At close, `frame_err_o` is 1 if the frame did not have exactly 14 edges, or if its opening low was neither 1 nor 3 bit periods long. The count runs from the opening falling edge up to and including the rising edge into the closing gap. The bits are delivered in either case.
- R7: A low run longer than `MAX_LOW` (4) bit periods ends the frame at its fifth low sample with a strobe carrying `frame_err_o`=1. Nothing more is reported until a full idle gap has been seen.
- R8: `long_cnt_o` and `short_cnt_o` count frames with `frame_err_o`=0 by type. Each updates one cycle after the strobe of such a frame and is otherwise unchanged.
- R9: When edges move by up to a quarter bit period, alternately early and late, the bits, type and error flag stay the same.
- R10: All timing is counted in `tick_i` pulses, `OVS` (8) per bit period. Changing the tick rate scales the bit period to match.
- R11: `frame_valid_o` is a single-cycle strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Data line, idle high; synchronised inside |
| tick_i | input | 1 | Time-base tick, `OVS` per bit period |
| frame_valid_o | output | 1 | One-cycle strobe when a frame ends |
| frame_type_o | output | 1 | 1 = long opening low, 0 = short |
| frame_bits_o | output | NBITS | Sampled bit-time levels, bit 0 first |
| frame_err_o | output | 1 | Edge count, opening low or low-run error |
| long_cnt_o | output | CNT_W | Good long-type frames since reset |
| short_cnt_o | output | CNT_W | Good short-type frames since reset |

## Verification
The assertions assume that frames end far enough apart that two strobes never fall in adjacent cycles. They also assume that reset is held from time zero, so the counters and output registers start from known values. The stimulus meets both conditions: every frame is followed by an idle gap of at least six bit periods, and every edge lands on a clock boundary. Edge displacement is kept to a quarter bit period, and it alternates in sign so that run lengths never drift enough to merge or split bit times.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    ST_WAIT_GAP = 2'd0,
    ST_IDLE     = 2'd1,
    ST_CAPT     = 2'd2
  } cap_state_e;

  localparam int unsigned TYPE_SHORT = 0;
  localparam int unsigned TYPE_LONG  = 1;
  localparam int unsigned NUM_TYPES  = 2;

endpackage

// File: rtl/pfc_line_sync.sv
module pfc_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic edge_o
);

  logic [STAGES-1:0] shift_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], line_i};
      prev_q  <= shift_q[STAGES-1];
    end
  end

  assign lvl_o  = shift_q[STAGES-1];
  assign edge_o = shift_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/pfc_bit_timer.sv
module pfc_bit_timer #(
  parameter int unsigned OVS   = 8,
  parameter int unsigned RUN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             edge_i,
  output logic             sample_o,
  output logic [RUN_W-1:0] run_o
);

  localparam int unsigned PH_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam int unsigned HALF = OVS / 2;

  logic [PH_W-1:0]  ph_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_inc;

  assign sample_o = tick_i && !edge_i && (ph_q == PH_W'(HALF - 1));
  assign run_inc  = (run_q == '1) ? run_q : run_q + 1'b1;
  assign run_o    = run_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= '0;
      run_q <= '0;
    end else if (edge_i) begin
      ph_q  <= '0;
      run_q <= '0;
    end else begin
      if (tick_i) begin
        ph_q <= (ph_q == PH_W'(OVS - 1)) ? '0 : ph_q + 1'b1;
      end
      if (sample_o) begin
        run_q <= run_inc;
      end
    end
  end

endmodule

// File: rtl/pfc_frame_fsm.sv
module pfc_frame_fsm
  import pfc_pkg::*;
#(
  parameter int unsigned NBITS      = 15,
  parameter int unsigned EDGES      = 14,
  parameter int unsigned LONG_LEAD  = 3,
  parameter int unsigned SHORT_LEAD = 1,
  parameter int unsigned MAX_LOW    = 4,
  parameter int unsigned GAP_BITS   = 6,
  parameter int unsigned RUN_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lvl_i,
  input  logic             edge_i,
  input  logic             sample_i,
  input  logic [RUN_W-1:0] run_i,
  output logic             valid_o,
  output logic             type_o,
  output logic             err_o,
  output logic [NBITS-1:0] bits_o
);

  localparam int unsigned IDX_W  = $clog2(NBITS + 1);
  localparam int unsigned EDGE_W = $clog2(EDGES + 2);
  localparam int unsigned LEAD_W = $clog2(LONG_LEAD + 2);

  cap_state_e        state_q;
  logic [NBITS-1:0]  work_q;
  logic [NBITS-1:0]  work_nx;
  logic [IDX_W-1:0]  idx_q;
  logic [EDGE_W-1:0] edges_q;
  logic [LEAD_W-1:0] lead_q;
  logic [LEAD_W-1:0] lead_nx;
  logic              first_q;
  logic              at_gap;
  logic              too_low;
  logic              lead_ok;
  logic              room;

  assign room    = (idx_q < IDX_W'(NBITS));
  assign at_gap  = sample_i && lvl_i && (run_i >= RUN_W'(GAP_BITS));
  assign too_low = sample_i && !lvl_i && (run_i > RUN_W'(MAX_LOW));
  assign lead_ok = (lead_q == LEAD_W'(LONG_LEAD)) || (lead_q == LEAD_W'(SHORT_LEAD));

  always_comb begin
    work_nx = work_q;
    if (room) begin
      work_nx[idx_q] = lvl_i;
    end
    lead_nx = lead_q;
    if (first_q && !lvl_i && (lead_q != '1)) begin
      lead_nx = lead_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_WAIT_GAP;
      work_q  <= '1;
      idx_q   <= '0;
      edges_q <= '0;
      lead_q  <= '0;
      first_q <= 1'b0;
      valid_o <= 1'b0;
      type_o  <= 1'b0;
      err_o   <= 1'b0;
      bits_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        ST_WAIT_GAP: begin
          if (at_gap) begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (edge_i && !lvl_i) begin
            state_q <= ST_CAPT;
            work_q  <= '1;
            idx_q   <= '0;
            edges_q <= EDGE_W'(1);
            lead_q  <= '0;
            first_q <= 1'b1;
          end
        end
        ST_CAPT: begin
          if (edge_i) begin
            if (edges_q != '1) begin
              edges_q <= edges_q + 1'b1;
            end
            if (lvl_i) begin
              first_q <= 1'b0;
            end
          end else if (sample_i) begin
            work_q <= work_nx;
            lead_q <= lead_nx;
            if (room) begin
              idx_q <= idx_q + 1'b1;
            end
            if (too_low) begin
              valid_o <= 1'b1;
              err_o   <= 1'b1;
              type_o  <= (lead_nx == LEAD_W'(LONG_LEAD));
              bits_o  <= work_nx;
              state_q <= ST_WAIT_GAP;
            end else if (at_gap) begin
              valid_o <= 1'b1;
              err_o   <= (edges_q != EDGE_W'(EDGES)) || !lead_ok;
              type_o  <= (lead_q == LEAD_W'(LONG_LEAD));
              bits_o  <= work_nx;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_WAIT_GAP;
      endcase
    end
  end

endmodule

// File: rtl/pfc_type_count.sv
module pfc_type_count
  import pfc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            valid_i,
  input  logic                            type_i,
  input  logic                            err_i,
  output logic [NUM_TYPES-1:0][CNT_W-1:0] cnt_o
);

  for (genvar t = 0; t < NUM_TYPES; t++) begin : g_type
    logic hit;
    assign hit = valid_i && !err_i && (type_i == 1'(t));
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_o[t] <= '0;
      end else if (hit) begin
        cnt_o[t] <= cnt_o[t] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pulse_frame_capture.sv
module pulse_frame_capture
  import pfc_pkg::*;
#(
  parameter int unsigned OVS         = 8,
  parameter int unsigned NBITS       = 15,
  parameter int unsigned EDGES       = 14,
  parameter int unsigned LONG_LEAD   = 3,
  parameter int unsigned SHORT_LEAD  = 1,
  parameter int unsigned MAX_LOW     = 4,
  parameter int unsigned GAP_BITS    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_i,
  input  logic             tick_i,
  output logic             frame_valid_o,
  output logic             frame_type_o,
  output logic [NBITS-1:0] frame_bits_o,
  output logic             frame_err_o,
  output logic [CNT_W-1:0] long_cnt_o,
  output logic [CNT_W-1:0] short_cnt_o
);

  localparam int unsigned RUN_MAX = (GAP_BITS > MAX_LOW + 1) ? GAP_BITS : MAX_LOW + 1;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 2);

  logic                            lvl;
  logic                            edge_det;
  logic                            sample;
  logic [RUN_W-1:0]                run;
  logic [NUM_TYPES-1:0][CNT_W-1:0] counts;

  pfc_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_i),
    .lvl_o  (lvl),
    .edge_o (edge_det)
  );

  pfc_bit_timer #(.OVS(OVS), .RUN_W(RUN_W)) timer_i (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick_i),
    .edge_i   (edge_det),
    .sample_o (sample),
    .run_o    (run)
  );

  pfc_frame_fsm #(
    .NBITS      (NBITS),
    .EDGES      (EDGES),
    .LONG_LEAD  (LONG_LEAD),
    .SHORT_LEAD (SHORT_LEAD),
    .MAX_LOW    (MAX_LOW),
    .GAP_BITS   (GAP_BITS),
    .RUN_W      (RUN_W)
  ) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .lvl_i    (lvl),
    .edge_i   (edge_det),
    .sample_i (sample),
    .run_i    (run),
    .valid_o  (frame_valid_o),
    .type_o   (frame_type_o),
    .err_o    (frame_err_o),
    .bits_o   (frame_bits_o)
  );

  pfc_type_count #(.CNT_W(CNT_W)) count_i (
    .clk     (clk),
    .rst     (rst),
    .valid_i (frame_valid_o),
    .type_i  (frame_type_o),
    .err_i   (frame_err_o),
    .cnt_o   (counts)
  );

  assign long_cnt_o  = counts[TYPE_LONG];
  assign short_cnt_o = counts[TYPE_SHORT];

endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int unsigned NBITS = 15,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_valid_o,
  input logic             frame_type_o,
  input logic             frame_err_o,
  input logic [NBITS-1:0] frame_bits_o,
  input logic [CNT_W-1:0] long_cnt_o,
  input logic [CNT_W-1:0] short_cnt_o
);

  // R11
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |=> !frame_valid_o);

  // R3
  bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_valid_o |-> ($stable(frame_bits_o) && $stable(frame_type_o) && $stable(frame_err_o)));

  // R8
  long_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid_o && !frame_err_o && frame_type_o)
      |=> ((long_cnt_o - $past(long_cnt_o)) == CNT_W'(1)) && $stable(short_cnt_o));

  // R8
  short_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_valid_o && !frame_err_o && !frame_type_o)
      |=> ((short_cnt_o - $past(short_cnt_o)) == CNT_W'(1)) && $stable(long_cnt_o));

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_valid_o || frame_err_o) |=> ($stable(long_cnt_o) && $stable(short_cnt_o)));

endmodule

bind pulse_frame_capture pfc_checker #(.NBITS(NBITS), .CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .frame_valid_o (frame_valid_o),
  .frame_type_o  (frame_type_o),
  .frame_err_o   (frame_err_o),
  .frame_bits_o  (frame_bits_o),
  .long_cnt_o    (long_cnt_o),
  .short_cnt_o   (short_cnt_o)
);

// File: tb/pulse_frame_capture_tb_top.sv
module pulse_frame_capture_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 8;
  localparam int NB         = 15;
  localparam int CW         = 8;

  typedef struct {
    logic [NB-1:0] bits;
    logic          typ;
    logic          err;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          line_i = 1'b1;
  logic          tick_i = 1'b0;
  logic          frame_valid_o;
  logic          frame_type_o;
  logic [NB-1:0] frame_bits_o;
  logic          frame_err_o;
  logic [CW-1:0] long_cnt_o;
  logic [CW-1:0] short_cnt_o;

  int   checks = 0;
  int   errors = 0;
  int   strobes = 0;
  int   tick_div = 2;
  int   bit_clk = 2 * OVS;
  int   exp_long = 0;
  int   exp_short = 0;
  bit   finished = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pulse_frame_capture dut_i (
    .clk           (clk),
    .rst           (rst),
    .line_i        (line_i),
    .tick_i        (tick_i),
    .frame_valid_o (frame_valid_o),
    .frame_type_o  (frame_type_o),
    .frame_bits_o  (frame_bits_o),
    .frame_err_o   (frame_err_o),
    .long_cnt_o    (long_cnt_o),
    .short_cnt_o   (short_cnt_o)
  );

  // R10: tick generator, tick_div clocks per tick
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc++;
      if (tc >= tick_div) begin
        tick_i = 1'b1;
        tc = 0;
      end else begin
        tick_i = 1'b0;
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop and compare on each strobe
  always @(negedge clk) begin
    if (!rst && frame_valid_o) begin
      exp_t e;
      strobes++;
      if (q.size() == 0) begin
        check(1'b0, "R2", "unexpected strobe bits", longint'(frame_bits_o), 0);
      end else begin
        e = q.pop_front();
        check(frame_bits_o == e.bits, e.tag, "bits", longint'(frame_bits_o), longint'(e.bits));
        check(frame_type_o == e.typ,  e.tag, "type", longint'(frame_type_o), longint'(e.typ));
        check(frame_err_o  == e.err,  e.tag, "err",  longint'(frame_err_o),  longint'(e.err));
      end
    end
  end

  task automatic hold(logic lvl, int n);
    line_i = lvl;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NB-1:0] long_pat();
    logic [NB-1:0] b;
    for (int i = 0; i < NB; i++) b[i] = (i < 3) ? 1'b0 : (((i - 3) % 2) == 0);
    return b;
  endfunction

  function automatic logic [NB-1:0] short_pat();
    logic [NB-1:0] b;
    for (int i = 0; i < NB; i++) b[i] = (i == NB - 1) ? 1'b1 : logic'(i % 2);
    return b;
  endfunction

  // drive one frame then a high gap; expected values from the requirements
  task automatic send_frame(logic [NB-1:0] b, int gap, int jit, bit expect_it, string tag);
    int   lead = 0;
    int   edges = 0;
    logic prev = 1'b1;
    exp_t e;
    int   i = 0;
    int   r = 0;
    while (lead < NB && b[lead] == 1'b0) lead++;
    for (int k = 0; k < NB; k++) begin
      if (b[k] != prev) edges++;
      prev = b[k];
    end
    if (prev != 1'b1) edges++;
    e.bits = b;
    e.typ  = (lead == 3);
    e.err  = (edges != 14) || !(lead == 1 || lead == 3);
    e.tag  = tag;
    if (expect_it) begin
      q.push_back(e);
      if (!e.err) begin
        if (e.typ) exp_long++;
        else       exp_short++;
      end
    end
    while (i < NB) begin
      logic lv = b[i];
      int   len = 0;
      while (i < NB && b[i] == lv) begin
        len++;
        i++;
      end
      hold(lv, len * bit_clk + (((r % 2) == 0) ? jit : -jit));
      r++;
    end
    hold(1'b1, gap * bit_clk);
  endtask

  initial begin
    int s0;
    exp_t e;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(frame_valid_o == 1'b0 && frame_type_o == 1'b0 && frame_err_o == 1'b0,
          "R1", "flags", {frame_valid_o, frame_type_o, frame_err_o}, 0);
    check(frame_bits_o == '0, "R1", "bits", longint'(frame_bits_o), 0);
    check(long_cnt_o == '0 && short_cnt_o == '0, "R1", "counts",
          {long_cnt_o, short_cnt_o}, 0);

    // R2: frame before any full gap is ignored
    hold(1'b1, 2 * bit_clk);
    send_frame(short_pat(), 10, 0, 1'b0, "R2");
    check(strobes == 0, "R2", "strobes before gap", strobes, 0);

    // R4 R3 R8: start-up burst 4 long, 23 short, 1 long
    for (int k = 0; k < 4; k++)  send_frame(long_pat(),  10, 0, 1'b1, "R4");
    for (int k = 0; k < 23; k++) send_frame(short_pat(), 10, 0, 1'b1, "R3");
    send_frame(long_pat(), 10, 0, 1'b1, "R4");

    // R6: wrong edge count, then wrong opening low length
    send_frame(15'b110011001100110, 10, 0, 1'b1, "R6");
    send_frame(15'b101010101010100, 10, 0, 1'b1, "R6");

    // R5: internal 5-bit high run does not close; 6-bit gap does
    send_frame(15'b010101010111110, 6, 0, 1'b1, "R5");
    send_frame(short_pat(), 6, 0, 1'b1, "R5");

    // R9: jittered edges
    send_frame(long_pat(),  10, 4, 1'b1, "R9");
    send_frame(short_pat(), 10, 4, 1'b1, "R9");
    send_frame(long_pat(),  10, -4, 1'b1, "R9");

    // R7: low run beyond limit aborts, then wait for gap
    s0 = strobes;
    e.bits = 15'b111111110000010;
    e.typ  = 1'b0;
    e.err  = 1'b1;
    e.tag  = "R7";
    q.push_back(e);
    hold(1'b0, bit_clk);
    hold(1'b1, bit_clk);
    hold(1'b0, 6 * bit_clk);
    hold(1'b1, 2 * bit_clk);
    hold(1'b0, bit_clk);
    hold(1'b1, 3 * bit_clk);
    hold(1'b0, 3 * bit_clk);
    hold(1'b1, 10 * bit_clk);
    check(strobes == s0 + 1, "R7", "strobes around abort", strobes, s0 + 1);
    send_frame(short_pat(), 10, 0, 1'b1, "R7");

    // R10: faster tick scales the bit period
    tick_div = 1;
    bit_clk  = OVS;
    hold(1'b1, 10 * bit_clk);
    send_frame(long_pat(),  10, 0, 1'b1, "R10");
    send_frame(short_pat(), 10, 0, 1'b1, "R10");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R3", "frames missing", q.size(), 0);
    // R8: running counts by type
    check(long_cnt_o == CW'(exp_long), "R8", "long count", longint'(long_cnt_o), exp_long);
    check(short_cnt_o == CW'(exp_short), "R8", "short count", longint'(short_cnt_o), exp_short);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule